// File: doc/BRIEF.md
# RAM window address decoder

This block sits between the CPU and DMA paths and an 8 MB main-memory range. It holds a 32-bit memory-size register. A 3-bit window code inside that register picks one of eight layouts. Each layout divides the 8 MB range into a backed memory part, an optional high-impedance part and an unmapped remainder.

CPU physical addresses reach the range through three mirrored segments, and the same layout applies to all three. Each access is sorted into one of three outcomes:

- a RAM hit, which is passed to the memory port;
- a high-Z hit, which reads as all ones and ignores writes;
- an unmapped hit, which reads as zero, drops writes and raises a one-cycle bus error.

DMA requests are compared against the size of the backed memory part. A request that would reach or cross that size gets a one-cycle bus error, and the channel uses it to drop its enable flag.

Top module: `ram_window_decoder`

## Requirements
- R1: After reset the size register reads 0x00000B88, which is window code 5, and every 1 MB slice of the 8 MB range is backed by RAM.
- R2: A register write stores all 32 bits, and the same value reads back on the next cycle. Only bits 11:9, the window code, change decoding; the other bits have no effect on any access outcome.
- R3: The window code selects the layout, given in MB from offset 0 as (RAM, high-Z, unmapped). Code 0 is (1,0,7), 1 is (4,0,4), 2 is (1,1,6), 3 is (4,4,0), 4 is (2,0,6), 5 is (8,0,0), 6 is (2,2,4) and 7 is (8,0,0).
- R4: Three segments carry the range: address bits 31:29 equal to 000, 100 or 101, with bits 28:23 all zero. The offset is bits 22:0, and ram_addr carries it. Any other address asserts neither ram_req nor cpu_bus_error.
- R5: A RAM hit asserts ram_req, asserts ram_we only for a write, forwards cpu_wdata, and returns ram_rdata on cpu_rdata in the same cycle.
- R6: A high-Z hit reads as 0xFFFFFFFF. It asserts neither ram_req nor cpu_bus_error.
- R7: An unmapped hit asserts no ram_req and reads as zero. It raises cpu_bus_error for exactly the one cycle after the access.
- R8: A window change applies to the very next access after the write cycle.
- R9: A DMA request whose byte address plus byte length is greater than or equal to the RAM size of the current layout raises dma_bus_error in the following cycle, for one cycle. Any other DMA request raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the size register |
| reg_wr_data | input | 32 | Value to store |
| reg_rd_data | output | 32 | Current register value |
| cpu_valid | input | 1 | CPU access present |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | CPU physical address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | Read data returned to the CPU |
| ram_rdata | input | 32 | Read data from the memory |
| ram_req | output | 1 | Access forwarded to memory |
| ram_we | output | 1 | Forwarded access is a write |
| ram_addr | output | 23 | Byte offset within the RAM range |
| ram_wdata | output | 32 | Write data to memory |
| cpu_bus_error | output | 1 | One-cycle pulse after an unmapped CPU access |
| dma_req | input | 1 | DMA transfer request |
| dma_addr | input | 32 | DMA start byte offset |
| dma_len | input | 32 | DMA length in bytes |
| dma_bus_error | output | 1 | One-cycle pulse refusing the DMA request |

## Verification
On every cycle, the assertions check four things:
- the register store and hold behaviour;
- that a CPU bus error follows a valid access that was never forwarded to memory;
- that a DMA error follows a DMA request;
- that a memory write is only forwarded for a CPU write.

Some behaviour can only be shown by the bench's scenarios. These are the exact layout of every window code in all three segments, the read values in high-Z and unmapped slices, and the DMA limit boundary at exact equality. They also include the one-cycle application of a new window code.

// File: rtl/ram_window_decoder.sv
module ram_window_decoder #(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter int          OFF_W       = 23,
  parameter int          SLICE_W     = 20,
  parameter int          WIN_LSB     = 9,
  parameter logic [31:0] RESET_VALUE = 32'h0000_0B88
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ram_req,
  output logic              ram_we,
  output logic [OFF_W-1:0]  ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              cpu_bus_error,
  input  logic              dma_req,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [ADDR_W-1:0] dma_len,
  output logic              dma_bus_error
);
  localparam int REGION_W = OFF_W - SLICE_W;
  localparam int LIMIT_W  = REGION_W + 1;
  localparam int SUM_W    = ADDR_W + 1;

  logic [DATA_W-1:0]  size_q;
  logic [2:0]         win;
  logic [LIMIT_W-1:0] mem_lim, hiz_lim, region;
  logic               seg_ok, access, in_ram, in_hiz;
  logic [SUM_W-1:0]   dma_end, mapped_bytes;

  assign win = size_q[WIN_LSB +: 3];

  always_comb begin
    case (win)
      3'd0:    begin mem_lim = LIMIT_W'(1); hiz_lim = LIMIT_W'(1); end
      3'd1:    begin mem_lim = LIMIT_W'(4); hiz_lim = LIMIT_W'(4); end
      3'd2:    begin mem_lim = LIMIT_W'(1); hiz_lim = LIMIT_W'(2); end
      3'd3:    begin mem_lim = LIMIT_W'(4); hiz_lim = LIMIT_W'(8); end
      3'd4:    begin mem_lim = LIMIT_W'(2); hiz_lim = LIMIT_W'(2); end
      3'd6:    begin mem_lim = LIMIT_W'(2); hiz_lim = LIMIT_W'(4); end
      default: begin mem_lim = LIMIT_W'(8); hiz_lim = LIMIT_W'(8); end
    endcase
  end

  assign seg_ok = (cpu_addr[ADDR_W-1 -: 3] == 3'b000 ||
                   cpu_addr[ADDR_W-1 -: 3] == 3'b100 ||
                   cpu_addr[ADDR_W-1 -: 3] == 3'b101) &&
                  (cpu_addr[ADDR_W-4:OFF_W] == '0);
  assign access = cpu_valid && seg_ok;
  assign region = {1'b0, cpu_addr[OFF_W-1:SLICE_W]};
  assign in_ram = region < mem_lim;
  assign in_hiz = !in_ram && (region < hiz_lim);

  assign ram_req   = access && in_ram;
  assign ram_we    = ram_req && cpu_write;
  assign ram_addr  = cpu_addr[OFF_W-1:0];
  assign ram_wdata = cpu_wdata;
  assign cpu_rdata = ram_req              ? ram_rdata :
                     (access && in_hiz)   ? '1        : '0;

  assign dma_end      = {1'b0, dma_addr} + {1'b0, dma_len};
  assign mapped_bytes = SUM_W'(mem_lim) << SLICE_W;

  assign reg_rd_data = size_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q        <= DATA_W'(RESET_VALUE);
      cpu_bus_error <= 1'b0;
      dma_bus_error <= 1'b0;
    end else begin
      if (reg_wr_en) size_q <= reg_wr_data;
      cpu_bus_error <= access && !in_ram && !in_hiz;
      dma_bus_error <= dma_req && (dma_end >= mapped_bytes);
    end
  end

  AST_REG_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> reg_rd_data == $past(reg_wr_data)); // R2
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_en |=> $stable(reg_rd_data)); // R2
  AST_ERR_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_bus_error |-> $past(cpu_valid)); // R7
  AST_ERR_NOT_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_bus_error |-> !$past(ram_req)); // R7
  AST_WE_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (cpu_write && cpu_valid)); // R5
  AST_DMA_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_bus_error |-> $past(dma_req)); // R9
endmodule

// File: tb/ram_window_decoder_bench.sv
module ram_window_decoder_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0, reg_rd_data;
  logic        cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = 32'h5555_AAAA, cpu_rdata;
  logic [31:0] ram_rdata = 32'hC0DE_0001;
  logic        ram_req, ram_we, cpu_bus_error;
  logic [22:0] ram_addr;
  logic [31:0] ram_wdata;
  logic        dma_req = 1'b0;
  logic [31:0] dma_addr = '0, dma_len = '0;
  logic        dma_bus_error;

  int checks = 0, fails = 0;
  int mem_mb [8] = '{1, 4, 1, 4, 2, 8, 2, 8};
  int hiz_mb [8] = '{1, 4, 2, 8, 2, 8, 4, 8};
  logic [31:0] seg_base [3] = '{32'h0000_0000, 32'h8000_0000, 32'hA000_0000};

  always #10 clk = ~clk;

  ram_window_decoder u_ram_window_decoder (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .ram_rdata(ram_rdata), .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .cpu_bus_error(cpu_bus_error), .dma_req(dma_req),
    .dma_addr(dma_addr), .dma_len(dma_len), .dma_bus_error(dma_bus_error));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_reg(input logic [31:0] v);
    reg_wr_en = 1'b1; reg_wr_data = v;
    @(posedge clk); @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // kind: 0 RAM, 1 high-Z, 2 unmapped, 3 outside the range
  task automatic probe(input logic [31:0] a, input logic wr, input int kind, input string req);
    cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a;
    #1;
    chk(req, {31'b0, ram_req}, {31'b0, kind == 0});
    chk(req, {31'b0, ram_we}, {31'b0, kind == 0 && wr});
    if (kind == 0) chk(req, {9'b0, ram_addr}, {9'b0, a[22:0]});
    if (kind == 0 && wr) chk(req, ram_wdata, cpu_wdata);
    if (!wr) chk(req, cpu_rdata, kind == 0 ? ram_rdata : kind == 1 ? 32'hFFFF_FFFF : 32'h0);
    @(posedge clk); @(negedge clk);
    cpu_valid = 1'b0;
    chk(req, {31'b0, cpu_bus_error}, {31'b0, kind == 2});
  endtask

  task automatic dma_probe(input logic [31:0] a, input logic [31:0] len, input int code);
    logic exp;
    exp = ({1'b0, a} + {1'b0, len}) >= (33'(mem_mb[code]) << 20);
    dma_req = 1'b1; dma_addr = a; dma_len = len;
    @(posedge clk); @(negedge clk);
    dma_req = 1'b0;
    chk("R9 dma error", {31'b0, dma_bus_error}, {31'b0, exp});
    @(posedge clk); @(negedge clk);
    chk("R9 dma pulse ends", {31'b0, dma_bus_error}, 32'b0);
  endtask

  task automatic t_reset;
    chk("R1 reset value", reg_rd_data, 32'h0000_0B88);
    for (int mb = 0; mb < 8; mb++) probe(32'h8000_0010 | (mb << 20), 1'b0, 0, "R1 full map");
  endtask

  task automatic t_register;
    set_reg(32'hA5A5_5A5A);
    chk("R2 readback", reg_rd_data, 32'hA5A5_5A5A);
    set_reg(32'h0000_0000);
    chk("R2 readback zero", reg_rd_data, 32'h0);
  endtask

  task automatic t_layouts;
    for (int code = 0; code < 8; code++) begin
      set_reg((32'hFFFF_F1FF) | (code << 9));
      for (int mb = 0; mb < 8; mb++) begin
        int kind;
        kind = mb < mem_mb[code] ? 0 : mb < hiz_mb[code] ? 1 : 2;
        for (int s = 0; s < 3; s++)
          probe(seg_base[s] | (mb << 20) | 32'h0000_0104, 1'b0, kind, "R3 R4 layout read");
        probe((mb << 20) | 32'h000F_FFFC, 1'b1, kind, "R5 R6 R7 layout write");
      end
    end
  endtask

  task automatic t_outside;
    set_reg(32'h0000_0B88);
    probe(32'h0080_0000, 1'b0, 3, "R4 beyond range");
    probe(32'h1F80_0000, 1'b1, 3, "R4 other region");
    probe(32'hC000_0000, 1'b0, 3, "R4 other segment");
  endtask

  task automatic t_switch;
    set_reg(32'h0000_0000);
    probe(32'h0010_0000, 1'b0, 2, "R8 new window at once");
    set_reg(32'h0000_0A00);
    probe(32'h0010_0000, 1'b0, 0, "R8 restored window");
  endtask

  task automatic t_dma;
    set_reg(32'h0000_0800);
    dma_probe(32'h001F_FF04, 32'h0000_0800, 4);
    dma_probe(32'h0000_1000, 32'h0000_0100, 4);
    dma_probe(32'h001F_FF00, 32'h0000_0100, 4);
    dma_probe(32'h001F_FF00, 32'h0000_00FF, 4);
    set_reg(32'h0000_0A00);
    dma_probe(32'h007F_F000, 32'h0000_1000, 5);
    dma_probe(32'h007F_F000, 32'h0000_0FFC, 5);
    set_reg(32'h0000_0000);
    dma_probe(32'h000F_0000, 32'h0000_FFFF, 0);
  endtask

  bit done = 0;
  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_register();
    t_layouts();
    t_outside();
    t_switch();
    t_dma();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule